// File: doc/BRIEF.md
# Significand Alignment Shifter with Parallel Sticky

This block moves the smaller operand's significand of a floating-point add to the right so that it lines up with the larger one. Its inputs are a significand that already carries the hidden one and a right-shift amount derived from the exponent difference. Its outputs are the aligned significand, the two bits that fall just below its least significant position (guard, then round), and a sticky flag. The sticky flag records whether any nonzero bit moved past the round position.

The shift happens in two levels. A fine level moves by 0 to 7 places using the low three count bits. A coarse level moves by multiples of eight using the upper count bits. Each level builds its own mask of the positions it discards, and the masks are placed over the unshifted input. The sticky flag therefore comes from the input in parallel with the shift and does not wait for the shifter. Counts large enough to move every bit past the round position saturate. A single-format operand uses the same datapath when it is placed zero-padded in the low 32 bits of the field. An optional output register adds one cycle of latency.

Top module: `asa_align_shift`

## Requirements
- R1: For a count below 56, `out_sig` equals bits [55:3] of the 56-bit value {in_sig, 3'b000} shifted right by the count.
- R2: `out_guard` and `out_round` are bits [2] and [1] of that shifted value. A count of 0 gives guard 0, round 0 and sticky 0 with `out_sig` equal to `in_sig`.
- R3: `out_sticky` is the OR of every `in_sig` bit i with i + 3 <= count, which means every bit that lands below the round position. Counts 0, 1 and 2 give sticky 0.
- R4: A count of 56 or more drives `out_sig`, `out_guard` and `out_round` to zero, and `out_sticky` is the OR of all bits of `in_sig`.
- R5: A single-format operand presented as {21'b0, 8'b0, 1'b1, f[22:0]} follows R1 to R4 unchanged, and no result bit above position 31 is ever set.
- R6: With the output register enabled, `out_valid` is high in exactly the cycle after `in_valid` was sampled high, and the result of that input appears in the same cycle.
- R7: During reset `out_valid` is 0 and all result outputs are 0.
- R8: A cycle with `in_valid` low leaves the result outputs holding the last produced result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input operand is valid this cycle |
| in_sig | input | 53 | Significand with hidden one |
| in_cnt | input | 6 | Right-shift amount |
| out_valid | output | 1 | Result valid |
| out_sig | output | 53 | Aligned significand |
| out_guard | output | 1 | First bit below the aligned LSB |
| out_round | output | 1 | Second bit below the aligned LSB |
| out_sticky | output | 1 | OR of all bits below the round position |

## Verification
A fault in either level's mask generator appears only on `out_sticky`, and only for counts whose discarded region covers a set input bit. For this reason every count from 0 to 63 is applied to sparse, dense and single-bit operands. A wrong coarse shift or mask offset corrupts the aligned field or the sticky flag one cycle after the input. A saturation threshold that is off by one shows up at counts 55 and 56. A fault in the output register's load or valid logic appears on the first idle cycle, either as a spurious `out_valid` or as result bits that changed when nothing was loaded.

// File: rtl/asa_pkg.sv
package asa_pkg;
   // bits kept below the aligned LSB before the sticky region starts
   localparam int GR_BITS = 2;
   // extra positions past guard/round at which everything is shifted out
   localparam int SAT_MARGIN = GR_BITS + 1;
endpackage

// File: rtl/asa_shift_level.sv
module asa_shift_level #(
   parameter int W     = 55,
   parameter int AMT_W = 3,
   parameter int STEP  = 1,
   parameter int OFF_W = 6
) (
   input  logic [W-1:0]     data_in,
   input  logic [AMT_W-1:0] amt,
   input  logic [OFF_W-1:0] offset,
   output logic [W-1:0]     data_out,
   output logic [W-1:0]     lost_mask
);
   localparam int STEP_LOG = (STEP > 1) ? $clog2(STEP) : 0;
   localparam int SPAN_W   = AMT_W + STEP_LOG + 1;

   if (STEP < 1) begin : g_bad_step
      $error("asa_shift_level: STEP must be at least 1");
   end
   if (W < 2) begin : g_bad_w
      $error("asa_shift_level: W too small");
   end

   logic [SPAN_W-1:0] span;
   assign span     = SPAN_W'(amt) * SPAN_W'(STEP);
   assign data_out = data_in >> span;

   // mask covers the input positions this level pushes out, placed at offset
   for (genvar j = 0; j < W; j++) begin : g_mask
      assign lost_mask[j] = (32'(j) >= 32'(offset)) &&
                            (32'(j) < 32'(offset) + 32'(span));
   end
endmodule

// File: rtl/asa_sticky_merge.sv
module asa_sticky_merge #(
   parameter int W = 55
) (
   input  logic [W-1:0] ext_in,
   input  logic [W-1:0] mask_fine,
   input  logic [W-1:0] mask_coarse,
   input  logic         saturate,
   output logic         sticky
);
   logic [W-1:0] hit;
   assign hit    = ext_in & (mask_fine | mask_coarse);
   assign sticky = saturate ? (|ext_in) : (|hit);
endmodule

// File: rtl/asa_align_shift.sv
module asa_align_shift #(
   parameter int SIG_W   = 53,
   parameter int CNT_W   = 6,
   parameter int FINE_W  = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SIG_W-1:0] in_sig,
   input  logic [CNT_W-1:0] in_cnt,
   output logic             out_valid,
   output logic [SIG_W-1:0] out_sig,
   output logic             out_guard,
   output logic             out_round,
   output logic             out_sticky
);
   import asa_pkg::*;

   localparam int EXT_W    = SIG_W + GR_BITS;
   localparam int COARSE_W = CNT_W - FINE_W;
   localparam int STEP_C   = 1 << FINE_W;
   localparam int SAT_CNT  = SIG_W + SAT_MARGIN;

   if (CNT_W <= FINE_W) begin : g_bad_split
      $error("asa_align_shift: CNT_W must exceed FINE_W");
   end
   if (SIG_W < 2) begin : g_bad_sig
      $error("asa_align_shift: SIG_W too small");
   end

   logic [EXT_W-1:0] ext, fine_out, coarse_out, fine_mask, coarse_mask;
   logic             sat, sticky_w;

   assign ext = {in_sig, {GR_BITS{1'b0}}};
   assign sat = 32'(in_cnt) >= SAT_CNT;

   asa_shift_level #(.W(EXT_W), .AMT_W(FINE_W), .STEP(1), .OFF_W(CNT_W)) u_fine (
      .data_in  (ext),
      .amt      (in_cnt[FINE_W-1:0]),
      .offset   ('0),
      .data_out (fine_out),
      .lost_mask(fine_mask)
   );

   asa_shift_level #(.W(EXT_W), .AMT_W(COARSE_W), .STEP(STEP_C), .OFF_W(CNT_W)) u_coarse (
      .data_in  (fine_out),
      .amt      (in_cnt[CNT_W-1:FINE_W]),
      .offset   (CNT_W'(in_cnt[FINE_W-1:0])),
      .data_out (coarse_out),
      .lost_mask(coarse_mask)
   );

   asa_sticky_merge #(.W(EXT_W)) u_sticky (
      .ext_in     (ext),
      .mask_fine  (fine_mask),
      .mask_coarse(coarse_mask),
      .saturate   (sat),
      .sticky     (sticky_w)
   );

   logic [SIG_W-1:0] res_sig;
   logic             res_g, res_r;
   assign res_sig = sat ? '0   : coarse_out[EXT_W-1:GR_BITS];
   assign res_g   = sat ? 1'b0 : coarse_out[1];
   assign res_r   = sat ? 1'b0 : coarse_out[0];

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sig    <= '0;
            out_guard  <= 1'b0;
            out_round  <= 1'b0;
            out_sticky <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_sig    <= res_sig;
               out_guard  <= res_g;
               out_round  <= res_r;
               out_sticky <= sticky_w;
            end
         end
      end

      p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      p_zero_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_cnt == '0) |=>
            (out_sig == $past(in_sig) && !out_guard && !out_round && !out_sticky));
      p_no_early_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && 32'(in_cnt) < SAT_MARGIN) |=> !out_sticky);
      p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && 32'(in_cnt) >= SAT_CNT) |=>
            (out_sig == '0 && !out_guard && !out_round && out_sticky == $past(|in_sig)));
      p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(out_sig) && $stable(out_sticky)));
   end else begin : g_comb
      assign out_valid  = in_valid;
      assign out_sig    = res_sig;
      assign out_guard  = res_g;
      assign out_round  = res_r;
      assign out_sticky = sticky_w;
   end
endmodule

// File: tb/asa_align_shift_bench.sv
module asa_align_shift_bench;
   localparam int SW = 53;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [SW-1:0] in_sig = '0;
   logic [CW-1:0] in_cnt = '0;
   logic          out_valid, out_guard, out_round, out_sticky;
   logic [SW-1:0] out_sig;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [SW+2:0] exp_q[$];
   string         tag_q[$];
   logic [SW+2:0] last_exp = '0;

   always #10 clk = ~clk;

   asa_align_shift u_asa_align_shift (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sig(in_sig), .in_cnt(in_cnt),
      .out_valid(out_valid), .out_sig(out_sig), .out_guard(out_guard),
      .out_round(out_round), .out_sticky(out_sticky)
   );

   function automatic logic [SW+2:0] model(input logic [SW-1:0] s, input logic [CW-1:0] c);
      logic [SW+2:0] wide, sh, drop;
      if (int'(c) >= SW + 3) return {{(SW + 2){1'b0}}, |s};
      wide = {s, 3'b000};
      sh   = wide >> c;
      drop = wide & (({{(SW + 2){1'b0}}, 1'b1} << c) - 1'b1);
      return {sh[SW+2:1], sh[0] | (|drop)};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [SW+2:0] got,
                        input logic [SW+2:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic drive(input logic [SW-1:0] s, input logic [CW-1:0] c, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_sig   = s;
      in_cnt   = c;
      exp_q.push_back(model(s, c));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sig   = '1;
         in_cnt   = '0;
      end
   endtask

   task automatic sweep(input logic [SW-1:0] s, input bit single);
      for (int c = 0; c < 64; c++) begin
         if (single)          drive(s, CW'(c), "R5");
         else if (c == 0)     drive(s, CW'(c), "R2");
         else if (c >= 56)    drive(s, CW'(c), "R4");
         else if (c < 3)      drive(s, CW'(c), "R1");
         else                 drive(s, CW'(c), "R3");
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: sample a quarter period after the rising edge
   always @(posedge clk) begin
      logic          v;
      logic [SW+2:0] got, exp;
      string         tg;
      v = in_valid;
      #5;
      if (rst_n) begin
         got = {out_sig, out_guard, out_round, out_sticky};
         check(out_valid == v, "R6", {{(SW + 2){1'b0}}, out_valid}, {{(SW + 2){1'b0}}, v});
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6", got, '0);
            end else begin
               exp = exp_q.pop_front();
               tg  = tag_q.pop_front();
               check(got == exp, tg, got, exp);
               if (tg == "R5")
                  check(got[SW+2:35] == '0, "R5", got, exp);
               last_exp = exp;
            end
         end else begin
            check(got == last_exp, "R8", got, last_exp);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check({out_valid, out_sig, out_guard, out_round, out_sticky} == '0, "R7",
            {out_sig, out_guard, out_round, out_sticky}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      sweep({1'b1, {(SW - 1){1'b0}}}, 1'b0);
      sweep('1, 1'b0);
      sweep({{(SW - 1){1'b0}}, 1'b1}, 1'b0);
      idle(2);
      sweep({SW{2'b01}}, 1'b0);
      sweep({1'b1, 30'h0, 22'h200001}, 1'b0);
      idle(1);
      sweep({21'b0, 8'b0, 1'b1, 23'h5A3C01}, 1'b1);
      sweep({21'b0, 8'b0, 1'b1, 23'h000000}, 1'b1);
      for (int c = 53; c < 58; c++) drive({1'b1, 51'h0, 1'b1}, CW'(c), "R4");
      idle(4);
      check(exp_q.size() == 0, "R6", SW'(exp_q.size()), '0);
      finish_run();
   end
endmodule